// File: doc/BRIEF.md
# Exception Entry Vector Controller

This block decides where a processor core goes when it takes an exception, and what architectural state it records on the way in. Each cycle it looks at four request lines: soft reset, debug entry, non-maskable interrupt and general exception. A general exception carries a 5-bit cause code, a TLB-miss flag and a coprocessor number. The block also reads the core's current status: exception level, error level, bootstrap-vector flag, interrupt mask, vectored-interrupt controls, spacing, exception base, faulting PC and delay-slot flag.

It accepts at most one request per cycle. On the next clock edge it presents the handler address and the kind of entry taken. In the same edge it updates the saved-PC registers it holds (general, error and debug), the cause code, the branch-delay bit and the coprocessor field. It also updates the status flags that the core should adopt. A small state machine records which kind of entry was committed in the last cycle. Its states are ST_IDLE, ST_GENERAL, ST_ERROR and ST_DEBUG. From any state it moves to the state matching the request that won arbitration, and it returns to ST_IDLE in any cycle without a request.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, pc_valid is 0, entry_kind is ST_IDLE (0) and every saved PC, pc_next, cause_code, cause_ce and cause_bd is 0. exl_o, erl_o, dm_o, sr_o and nmi_o are 0, and bev_o is 1.
- R2: Only one request is accepted per cycle. The priority order is soft reset, then debug, then NMI, then general exception. The result appears one clock edge after the request. pc_valid is high for exactly that cycle, and entry_kind shows the entry taken: 1 for general, 2 for error, 3 for debug.
- R3: A general exception jumps to base plus offset. The base is 0xBFC00200 when st_bev is 1. Otherwise it is exc_base with its low 10 bits cleared. The offset is 0x180 unless R4, R5 or R7 applies.
- R4: Cause codes 2 and 3 with tlb_miss set use offset 0x000 while st_exl is 0. When st_exl is 1 they use 0x180.
- R5: Cause code 0 with iv_en set uses offset 0x200 when st_bev is 1 or vec_spacing is 0. Otherwise the offset is 0x200 + vector × vec_spacing × 32, where the vector is the index of the highest set bit of irq_pending AND st_im. The vector is 0 when that AND is empty. With iv_en clear, the offset is 0x180.
- R6: When eic_mode is set, the vector is the value of irq_pending itself, and st_im is ignored.
- R7: Cause code 30 (cache error) uses offset 0x100 when st_bev is 1 and 0x20000100 otherwise.
- R8: A general entry with st_exl 0 loads epc with the adjusted PC: fault_pc, or fault_pc − 4 when in_delay is 1. It also sets cause_bd equal to in_delay. With st_exl 1, epc and cause_bd keep their values. exl_o is 1 after any general entry.
- R9: Every general entry writes exc_code into cause_code. Code 11 also writes cop_num into cause_ce. Any other code leaves cause_ce unchanged.
- R10: Soft reset and NMI load error_epc with the adjusted PC, set erl_o and bev_o, and jump to 0xBFC00000. Soft reset sets sr_o, NMI sets nmi_o, and epc is not changed.
- R11: A debug entry loads debug_epc with the adjusted PC, sets dm_o and jumps to 0xBFC00480.
- R12: An error or debug entry clears cause_bd when st_exl is 0, keeps it when st_exl is 1, and never changes cause_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srst_req | input | 1 | Soft reset request |
| dbg_req | input | 1 | Debug entry request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| exc_req | input | 1 | General exception request |
| exc_code | input | CODE_W | Cause code of the general exception |
| tlb_miss | input | 1 | No translation matched (refill case) |
| cop_num | input | CE_W | Coprocessor number for code 11 |
| irq_pending | input | IRQ_W | Pending interrupt lines, or vector in controller mode |
| st_exl | input | 1 | Current exception level |
| st_erl | input | 1 | Current error level |
| st_bev | input | 1 | Current bootstrap-vector flag |
| st_im | input | IRQ_W | Interrupt mask |
| iv_en | input | 1 | Vectored interrupts enabled |
| eic_mode | input | 1 | External controller supplies the vector |
| vec_spacing | input | SPC_W | Vector spacing in 32-byte units |
| exc_base | input | ADDR_W | Programmable exception base |
| fault_pc | input | ADDR_W | PC of the excepting instruction |
| in_delay | input | 1 | Excepting instruction sits in a branch delay slot |
| pc_valid | output | 1 | pc_next is a new handler address this cycle |
| pc_next | output | ADDR_W | Handler address |
| entry_kind | output | 2 | Entry taken: 0 none, 1 general, 2 error, 3 debug |
| epc | output | ADDR_W | Saved PC for general exceptions |
| error_epc | output | ADDR_W | Saved PC for soft reset / NMI |
| debug_epc | output | ADDR_W | Saved PC for debug entry |
| cause_code | output | CODE_W | Cause code field |
| cause_bd | output | 1 | Branch-delay bit of the cause field |
| cause_ce | output | CE_W | Coprocessor number field |
| exl_o | output | 1 | Exception level after the entry |
| erl_o | output | 1 | Error level after the entry |
| bev_o | output | 1 | Bootstrap-vector flag after the entry |
| dm_o | output | 1 | Debug mode flag |
| sr_o | output | 1 | Soft reset occurred |
| nmi_o | output | 1 | NMI occurred |

## Verification
Each request affects the outputs through exactly one register stage. The handler address, entry kind, saved PCs, cause fields and flags all change at the first rising edge after the request is presented, and pc_valid drops again one edge later. The bench applies each stimulus at a falling edge and samples everything at the following falling edge, half a period after the edge that commits the entry. It then takes one empty cycle to confirm that pc_valid has dropped and that the held registers have not moved.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GENERAL = 2'd1,
        ST_ERROR   = 2'd2,
        ST_DEBUG   = 2'd3
    } entry_state_t;

    // request source indices, lower index wins
    localparam int SRC_SRST = 0;
    localparam int SRC_DBG  = 1;
    localparam int SRC_NMI  = 2;
    localparam int SRC_GEN  = 3;
    localparam int N_SRC    = 4;

    // fixed handler addresses
    localparam logic [31:0] BOOT_GEN_BASE = 32'hBFC0_0200;
    localparam logic [31:0] ERR_ENTRY_PC  = 32'hBFC0_0000;
    localparam logic [31:0] DBG_ENTRY_PC  = 32'hBFC0_0480;

    // offsets from the general base
    localparam logic [31:0] OFS_DEFAULT    = 32'h0000_0180;
    localparam logic [31:0] OFS_REFILL     = 32'h0000_0000;
    localparam logic [31:0] OFS_IRQ        = 32'h0000_0200;
    localparam logic [31:0] OFS_CACHE_BOOT = 32'h0000_0100;
    localparam logic [31:0] OFS_CACHE_RUN  = 32'h2000_0100;

    localparam int BASE_ALIGN_BITS = 10;
    localparam int SPACING_SHIFT   = 5;

    // cause codes with special handling
    localparam int CODE_INT   = 0;
    localparam int CODE_TLBL  = 2;
    localparam int CODE_TLBS  = 3;
    localparam int CODE_CPU   = 11;
    localparam int CODE_CACHE = 30;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    logic taken;

    // fixed priority: lowest index first, one grant at most
    always_comb begin
        gnt   = '0;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/exc_irq_vector.sv
module exc_irq_vector
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IRQ_W  = 8,
    parameter int SPC_W  = 5
) (
    input  logic [IRQ_W-1:0]  irq_pending,
    input  logic [IRQ_W-1:0]  st_im,
    input  logic              eic_mode,
    input  logic              st_bev,
    input  logic [SPC_W-1:0]  vec_spacing,
    output logic [ADDR_W-1:0] irq_ofs
);

    logic [IRQ_W-1:0]  masked;
    logic [IRQ_W-1:0]  hi_idx;
    logic [IRQ_W-1:0]  vec_num;
    logic [ADDR_W-1:0] stride;

    assign masked = irq_pending & st_im;

    // highest set bit of the enabled pending lines
    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < IRQ_W; i++) begin
            if (masked[i]) hi_idx = IRQ_W'(i);
        end
    end

    assign vec_num = eic_mode ? irq_pending : hi_idx;
    assign stride  = ADDR_W'(vec_spacing) << SPACING_SHIFT;

    always_comb begin
        if (st_bev || (vec_spacing == '0)) begin
            irq_ofs = ADDR_W'(OFS_IRQ);
        end else begin
            irq_ofs = ADDR_W'(OFS_IRQ) + ADDR_W'(vec_num) * stride;
        end
    end

endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] exc_code,
    input  logic              tlb_miss,
    input  logic              st_exl,
    input  logic              st_bev,
    input  logic              iv_en,
    input  logic [ADDR_W-1:0] exc_base,
    input  logic [ADDR_W-1:0] irq_ofs,
    output logic [ADDR_W-1:0] gen_pc
);

    localparam logic [ADDR_W-1:0] BASE_MASK =
        ~((ADDR_W'(1) << BASE_ALIGN_BITS) - ADDR_W'(1));

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] offset;
    logic              is_refill;

    assign base = st_bev ? ADDR_W'(BOOT_GEN_BASE) : (exc_base & BASE_MASK);

    assign is_refill = tlb_miss && !st_exl &&
                       ((exc_code == CODE_W'(CODE_TLBL)) ||
                        (exc_code == CODE_W'(CODE_TLBS)));

    always_comb begin
        if (exc_code == CODE_W'(CODE_CACHE)) begin
            offset = st_bev ? ADDR_W'(OFS_CACHE_BOOT) : ADDR_W'(OFS_CACHE_RUN);
        end else if (is_refill) begin
            offset = ADDR_W'(OFS_REFILL);
        end else if ((exc_code == CODE_W'(CODE_INT)) && iv_en) begin
            offset = irq_ofs;
        end else begin
            offset = ADDR_W'(OFS_DEFAULT);
        end
    end

    assign gen_pc = base + offset;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IRQ_W  = 8,
    parameter int SPC_W  = 5,
    parameter int CODE_W = 5,
    parameter int CE_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              srst_req,
    input  logic              dbg_req,
    input  logic              nmi_req,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              tlb_miss,
    input  logic [CE_W-1:0]   cop_num,
    input  logic [IRQ_W-1:0]  irq_pending,
    input  logic              st_exl,
    input  logic              st_erl,
    input  logic              st_bev,
    input  logic [IRQ_W-1:0]  st_im,
    input  logic              iv_en,
    input  logic              eic_mode,
    input  logic [SPC_W-1:0]  vec_spacing,
    input  logic [ADDR_W-1:0] exc_base,
    input  logic [ADDR_W-1:0] fault_pc,
    input  logic              in_delay,
    output logic              pc_valid,
    output logic [ADDR_W-1:0] pc_next,
    output logic [1:0]        entry_kind,
    output logic [ADDR_W-1:0] epc,
    output logic [ADDR_W-1:0] error_epc,
    output logic [ADDR_W-1:0] debug_epc,
    output logic [CODE_W-1:0] cause_code,
    output logic              cause_bd,
    output logic [CE_W-1:0]   cause_ce,
    output logic              exl_o,
    output logic              erl_o,
    output logic              bev_o,
    output logic              dm_o,
    output logic              sr_o,
    output logic              nmi_o
);

    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    logic [N_SRC-1:0]  src_req;
    logic [N_SRC-1:0]  src_gnt;
    logic [ADDR_W-1:0] irq_ofs;
    logic [ADDR_W-1:0] gen_pc;
    logic [ADDR_W-1:0] resume_pc;
    entry_state_t      state_q;
    entry_state_t      state_d;

    assign src_req[SRC_SRST] = srst_req;
    assign src_req[SRC_DBG]  = dbg_req;
    assign src_req[SRC_NMI]  = nmi_req;
    assign src_req[SRC_GEN]  = exc_req;

    exc_arbiter #(.N(N_SRC)) u_arb (
        .req (src_req),
        .gnt (src_gnt)
    );

    exc_irq_vector #(
        .ADDR_W (ADDR_W),
        .IRQ_W  (IRQ_W),
        .SPC_W  (SPC_W)
    ) u_irq (
        .irq_pending (irq_pending),
        .st_im       (st_im),
        .eic_mode    (eic_mode),
        .st_bev      (st_bev),
        .vec_spacing (vec_spacing),
        .irq_ofs     (irq_ofs)
    );

    exc_vector_calc #(
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_calc (
        .exc_code (exc_code),
        .tlb_miss (tlb_miss),
        .st_exl   (st_exl),
        .st_bev   (st_bev),
        .iv_en    (iv_en),
        .exc_base (exc_base),
        .irq_ofs  (irq_ofs),
        .gen_pc   (gen_pc)
    );

    // PC to return to: back up to the branch when in a delay slot
    assign resume_pc = in_delay ? (fault_pc - INSN_BYTES) : fault_pc;

    // next-state decode from the winning request
    always_comb begin
        state_d = ST_IDLE;
        if (src_gnt[SRC_SRST] || src_gnt[SRC_NMI]) begin
            state_d = ST_ERROR;
        end else if (src_gnt[SRC_DBG]) begin
            state_d = ST_DEBUG;
        end else if (src_gnt[SRC_GEN]) begin
            state_d = ST_GENERAL;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign entry_kind = state_q;
    assign pc_valid   = (state_q != ST_IDLE);

    // architectural outputs, written in the committing edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_next    <= '0;
            epc        <= '0;
            error_epc  <= '0;
            debug_epc  <= '0;
            cause_code <= '0;
            cause_bd   <= 1'b0;
            cause_ce   <= '0;
            exl_o      <= 1'b0;
            erl_o      <= 1'b0;
            bev_o      <= 1'b1;
            dm_o       <= 1'b0;
            sr_o       <= 1'b0;
            nmi_o      <= 1'b0;
        end else begin
            unique case (state_d)
                ST_IDLE: begin
                end
                ST_GENERAL: begin
                    pc_next    <= gen_pc;
                    cause_code <= exc_code;
                    if (exc_code == CODE_W'(CODE_CPU)) begin
                        cause_ce <= cop_num;
                    end
                    if (!st_exl) begin
                        epc      <= resume_pc;
                        cause_bd <= in_delay;
                    end
                    exl_o <= 1'b1;
                    erl_o <= st_erl;
                    bev_o <= st_bev;
                end
                ST_ERROR: begin
                    pc_next   <= ADDR_W'(ERR_ENTRY_PC);
                    error_epc <= resume_pc;
                    if (!st_exl) begin
                        cause_bd <= 1'b0;
                    end
                    exl_o <= st_exl;
                    erl_o <= 1'b1;
                    bev_o <= 1'b1;
                    if (src_gnt[SRC_SRST]) begin
                        sr_o <= 1'b1;
                    end else begin
                        nmi_o <= 1'b1;
                    end
                end
                ST_DEBUG: begin
                    pc_next   <= ADDR_W'(DBG_ENTRY_PC);
                    debug_epc <= resume_pc;
                    if (!st_exl) begin
                        cause_bd <= 1'b0;
                    end
                    exl_o <= st_exl;
                    erl_o <= st_erl;
                    bev_o <= st_bev;
                    dm_o  <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
    import exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              srst_req,
    input logic              dbg_req,
    input logic              nmi_req,
    input logic              exc_req,
    input logic              st_exl,
    input logic              in_delay,
    input logic [ADDR_W-1:0] fault_pc,
    input logic              pc_valid,
    input logic [ADDR_W-1:0] pc_next,
    input logic [1:0]        entry_kind,
    input logic [ADDR_W-1:0] epc,
    input logic              cause_bd,
    input logic              exl_o,
    input logic              erl_o,
    input logic              bev_o,
    input logic              dm_o,
    input logic              sr_o,
    input logic              nmi_o
);

    logic gen_win;
    assign gen_win = exc_req && !srst_req && !dbg_req && !nmi_req;

    a_r2_srst_first: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> (pc_next == ADDR_W'(ERR_ENTRY_PC)) && sr_o && erl_o && bev_o
                     && (entry_kind == 2'd2));

    a_r11_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req && !srst_req) |=> (pc_next == ADDR_W'(DBG_ENTRY_PC)) && dm_o
                                   && (entry_kind == 2'd3));

    a_r10_nmi_keeps_epc: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !srst_req && !dbg_req) |=> $stable(epc) && nmi_o && erl_o);

    a_r8_hold_at_exl: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_win && st_exl) |=> $stable(epc) && $stable(cause_bd) && exl_o);

    a_r8_epc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_win && !st_exl && !in_delay) |=> (epc == $past(fault_pc)) && exl_o);

    a_r2_quiet_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !(srst_req || dbg_req || nmi_req || exc_req) |=> !pc_valid && $stable(epc));

endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst_req   (srst_req),
    .dbg_req    (dbg_req),
    .nmi_req    (nmi_req),
    .exc_req    (exc_req),
    .st_exl     (st_exl),
    .in_delay   (in_delay),
    .fault_pc   (fault_pc),
    .pc_valid   (pc_valid),
    .pc_next    (pc_next),
    .entry_kind (entry_kind),
    .epc        (epc),
    .cause_bd   (cause_bd),
    .exl_o      (exl_o),
    .erl_o      (erl_o),
    .bev_o      (bev_o),
    .dm_o       (dm_o),
    .sr_o       (sr_o),
    .nmi_o      (nmi_o)
);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        srst_req = 0, dbg_req = 0, nmi_req = 0, exc_req = 0;
    logic [4:0]  exc_code = '0;
    logic        tlb_miss = 0;
    logic [1:0]  cop_num = '0;
    logic [7:0]  irq_pending = '0;
    logic        st_exl = 0, st_erl = 0, st_bev = 0;
    logic [7:0]  st_im = '0;
    logic        iv_en = 0, eic_mode = 0;
    logic [4:0]  vec_spacing = '0;
    logic [31:0] exc_base = 32'h8000_1234;
    logic [31:0] fault_pc = 32'h0040_0000;
    logic        in_delay = 0;

    logic        pc_valid;
    logic [31:0] pc_next, epc, error_epc, debug_epc;
    logic [1:0]  entry_kind;
    logic [4:0]  cause_code;
    logic        cause_bd;
    logic [1:0]  cause_ce;
    logic        exl_o, erl_o, bev_o, dm_o, sr_o, nmi_o;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of held state
    logic [31:0] m_epc = '0;
    logic        m_bd = 0;
    logic [1:0]  m_ce = '0;
    logic [4:0]  m_code = '0;

    always #5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n),
        .srst_req(srst_req), .dbg_req(dbg_req), .nmi_req(nmi_req), .exc_req(exc_req),
        .exc_code(exc_code), .tlb_miss(tlb_miss), .cop_num(cop_num),
        .irq_pending(irq_pending), .st_exl(st_exl), .st_erl(st_erl), .st_bev(st_bev),
        .st_im(st_im), .iv_en(iv_en), .eic_mode(eic_mode), .vec_spacing(vec_spacing),
        .exc_base(exc_base), .fault_pc(fault_pc), .in_delay(in_delay),
        .pc_valid(pc_valid), .pc_next(pc_next), .entry_kind(entry_kind),
        .epc(epc), .error_epc(error_epc), .debug_epc(debug_epc),
        .cause_code(cause_code), .cause_bd(cause_bd), .cause_ce(cause_ce),
        .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o), .dm_o(dm_o),
        .sr_o(sr_o), .nmi_o(nmi_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: requests are live across the rising edge, results sampled at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        srst_req = 0; dbg_req = 0; nmi_req = 0; exc_req = 0;
    endtask

    function automatic logic [31:0] m_base(input logic bev, input logic [31:0] b);
        return bev ? 32'hBFC0_0200 : {b[31:10], 10'b0};
    endfunction

    function automatic logic [31:0] m_irq_ofs(input logic [7:0] pend, input logic [7:0] im,
                                              input logic eic, input logic bev,
                                              input logic [4:0] spc);
        logic [31:0] v;
        logic [7:0]  m;
        if (bev || spc == 0) return 32'h200;
        m = pend & im;
        v = 0;
        if (eic) v = {24'b0, pend};
        else begin
            for (int i = 7; i >= 0; i--) begin
                if (m[i]) begin v = i; break; end
            end
        end
        return 32'h200 + v * spc * 32;
    endfunction

    task automatic gen_exc(input logic [4:0] code, input logic miss, input logic exl,
                           input logic bev, input logic dly, input logic [31:0] pc);
        exc_code = code; tlb_miss = miss; st_exl = exl; st_bev = bev;
        in_delay = dly; fault_pc = pc; exc_req = 1;
        step();
        if (!exl) begin
            m_epc = dly ? pc - 4 : pc;
            m_bd  = dly;
        end
        m_code = code;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [4:0] codes [9];
        codes = '{5'd8, 5'd9, 5'd10, 5'd12, 5'd13, 5'd2, 5'd3, 5'd30, 5'd4};

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pc_valid", {31'b0, pc_valid}, 0);
        chk("R1 entry_kind", {30'b0, entry_kind}, 0);
        chk("R1 pc_next", pc_next, 0);
        chk("R1 epc", epc, 0);
        chk("R1 error_epc", error_epc, 0);
        chk("R1 debug_epc", debug_epc, 0);
        chk("R1 cause", {cause_code, cause_bd, cause_ce}, 0);
        chk("R1 flags exl,erl,bev,dm,sr,nmi", {exl_o, erl_o, bev_o, dm_o, sr_o, nmi_o}, 6'b001000);
        rst_n = 1;
        @(negedge clk);

        // R3 R4 R7 R8 R9 sweep over codes and status
        for (int c = 0; c < 9; c++) begin
            for (int k = 0; k < 16; k++) begin
                logic [31:0] exp_pc, pcv;
                logic bev, exl, miss, dly;
                bev = k[0]; exl = k[1]; miss = k[2]; dly = k[3];
                pcv = 32'h0040_0000 + (c * 16 + k) * 8;
                gen_exc(codes[c], miss, exl, bev, dly, pcv);
                if (codes[c] == 30)
                    exp_pc = m_base(bev, exc_base) + (bev ? 32'h100 : 32'h2000_0100);   // R7
                else if ((codes[c] == 2 || codes[c] == 3) && miss && !exl)
                    exp_pc = m_base(bev, exc_base);                                    // R4
                else
                    exp_pc = m_base(bev, exc_base) + 32'h180;                          // R3
                chk("R3 R4 R7 handler pc", pc_next, exp_pc);
                chk("R8 epc", epc, m_epc);
                chk("R8 cause_bd", {31'b0, cause_bd}, {31'b0, m_bd});
                chk("R8 exl_o", {31'b0, exl_o}, 1);
                chk("R9 cause_code", {27'b0, cause_code}, {27'b0, m_code});
                chk("R2 entry general", {30'b0, entry_kind}, 1);
            end
        end
        step();
        chk("R2 pc_valid drops", {31'b0, pc_valid}, 0);

        // R5 vectored interrupts, masked highest bit
        iv_en = 1; eic_mode = 0;
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 256; p++) begin
                vec_spacing = (s == 0) ? 5'd1 : 5'd4;
                st_im = (s == 0) ? 8'hA5 : 8'hFF;
                irq_pending = p[7:0];
                gen_exc(5'd0, 0, 0, 0, 0, 32'h0010_0000);
                chk("R5 vectored pc", pc_next,
                    m_base(0, exc_base) + m_irq_ofs(p[7:0], st_im, 0, 0, vec_spacing));
            end
        end
        // R5 bootstrap or zero spacing, and vectoring disabled
        irq_pending = 8'h80; st_im = 8'hFF; vec_spacing = 5'd3;
        gen_exc(5'd0, 0, 0, 1, 0, 32'h0010_0000);
        chk("R5 bev gives 0x200", pc_next, 32'hBFC0_0400);
        vec_spacing = 5'd0;
        gen_exc(5'd0, 0, 0, 0, 0, 32'h0010_0000);
        chk("R5 spacing 0 gives 0x200", pc_next, m_base(0, exc_base) + 32'h200);
        vec_spacing = 5'd3; iv_en = 0;
        gen_exc(5'd0, 0, 0, 0, 0, 32'h0010_0000);
        chk("R5 iv disabled gives 0x180", pc_next, m_base(0, exc_base) + 32'h180);

        // R6 external controller: pending value is the vector, mask ignored
        iv_en = 1; eic_mode = 1; st_im = 8'h00; vec_spacing = 5'd2;
        for (int p = 0; p < 256; p++) begin
            irq_pending = p[7:0];
            gen_exc(5'd0, 0, 0, 0, 0, 32'h0020_0000);
            chk("R6 eic vector pc", pc_next, m_base(0, exc_base) + 32'h200 + p * 64);
        end
        eic_mode = 0; iv_en = 0;

        // R9 coprocessor number
        for (int n = 0; n < 4; n++) begin
            cop_num = n[1:0];
            gen_exc(5'd11, 0, 0, 0, 0, 32'h0030_0000);
            m_ce = n[1:0];
            chk("R9 cause_ce on code 11", {30'b0, cause_ce}, {30'b0, m_ce});
            chk("R9 code 11", {27'b0, cause_code}, 11);
        end
        cop_num = 2'd1;
        gen_exc(5'd8, 0, 0, 0, 0, 32'h0030_0100);
        chk("R9 cause_ce held on other code", {30'b0, cause_ce}, {30'b0, m_ce});

        // set bd so R12 clearing is visible
        gen_exc(5'd9, 0, 0, 0, 1, 32'h0030_0200);
        chk("R8 bd set", {31'b0, cause_bd}, 1);

        // R10 NMI with delay slot, exl clear
        st_exl = 0; in_delay = 1; fault_pc = 32'h0050_0010; nmi_req = 1; st_bev = 0;
        step();
        chk("R10 nmi pc", pc_next, 32'hBFC0_0000);
        chk("R10 error_epc", error_epc, 32'h0050_000C);
        chk("R10 flags erl,bev,nmi,sr", {erl_o, bev_o, nmi_o, sr_o}, 4'b1110);
        chk("R10 epc untouched", epc, m_epc);
        chk("R12 bd cleared", {31'b0, cause_bd}, 0);
        chk("R12 code kept", {27'b0, cause_code}, {27'b0, m_code});
        chk("R2 entry error", {30'b0, entry_kind}, 2);

        // R12 bd kept at exl, via debug entry
        gen_exc(5'd10, 0, 0, 0, 1, 32'h0030_0300);
        st_exl = 1; in_delay = 0; fault_pc = 32'h0060_0000; dbg_req = 1;
        step();
        chk("R11 debug pc", pc_next, 32'hBFC0_0480);
        chk("R11 debug_epc", debug_epc, 32'h0060_0000);
        chk("R11 dm_o", {31'b0, dm_o}, 1);
        chk("R12 bd kept at exl", {31'b0, cause_bd}, 1);
        chk("R2 entry debug", {30'b0, entry_kind}, 3);

        // R2 priority
        st_exl = 0; fault_pc = 32'h0070_0000;
        srst_req = 1; dbg_req = 1; nmi_req = 1; exc_req = 1; exc_code = 5'd8;
        step();
        chk("R2 soft reset wins", pc_next, 32'hBFC0_0000);
        chk("R10 sr_o", {31'b0, sr_o}, 1);
        chk("R2 epc untouched", epc, m_epc);
        fault_pc = 32'h0070_0100;
        dbg_req = 1; nmi_req = 1; exc_req = 1;
        step();
        chk("R2 debug beats nmi", pc_next, 32'hBFC0_0480);
        chk("R2 debug_epc", debug_epc, 32'h0070_0100);
        fault_pc = 32'h0070_0200;
        nmi_req = 1; exc_req = 1;
        step();
        chk("R2 nmi beats general", error_epc, 32'h0070_0200);
        chk("R2 epc still untouched", epc, m_epc);
        step();
        chk("R2 idle after entry", {31'b0, pc_valid}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule